// File: doc/BRIEF.md
# PC Card Target Access Controller

This block sits on the card side of a PC Card style memory bus. It watches the host's two card-enable lines, the space-select line and the read and write strobes. From their levels it sorts every host access into one of four kinds: a read or a write of common memory, or a read or a write of attribute memory. Common-memory accesses become requests on a request/acknowledge memory port. That port feeds an external arbiter, which shares the memory with another client. Attribute accesses are served from a small register file inside the block.

All host control lines pass through a two-stage synchronizer before they are decoded. A memory request stays asserted, with frozen address, data and direction, until the memory side returns its one-cycle acknowledge. For reads, the returned word is held and presented to the host data pads together with a pad output-enable. That enable is high only while a read result is being held, the card is enabled and the read strobe is low. After any access the block waits for both strobes to return high before it will decode again, so one long strobe can never start a second access.

Top module: `pcc_target`

## Requirements
- R1: An access is recognised only while `host_ce_n` differs from binary 11. With both card-enable lines high, no memory request is made, the pads are not driven and no attribute register changes.
- R2: `host_reg_n` high selects common memory, which is served through the memory port. `host_reg_n` low selects attribute memory, which never raises `mem_req`.
- R3: A common-memory read raises `mem_req` with `mem_wr` = 0 and `mem_addr` equal to `host_addr`. The `mem_rdata` word sampled with `mem_ack` then appears on `host_rd_data`.
- R4: A common-memory write raises `mem_req` with `mem_wr` = 1, and with `mem_addr` and `mem_wdata` equal to the host address and data.
- R5: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_wr`, `mem_addr` and `mem_wdata` stay unchanged. The cycle after `mem_ack`, `mem_req` is low.
- R6: A strobe falling on the pins, with the card already enabled, raises `mem_req` on the third rising clock edge after the change.
- R7: An attribute write stores `host_wr_data[7:0]` into register `host_addr[3:0]` of 16 byte-wide registers. Address bits above bit 3 do not select a register.
- R8: An attribute read returns the addressed register zero-extended to 16 bits (upper byte 0) on `host_rd_data`.
- R9: After an access completes, the block decodes no new access until both `host_oe_n` and `host_we_n` have been seen high. A strobe held low for many cycles yields exactly one memory request.
- R10: `host_rd_oe` is high only while a read result is held, the card is enabled and `host_oe_n` is low. It falls on the second rising edge after `host_oe_n` rises.
- R11: After reset, `mem_req` and `host_rd_oe` are low and every attribute register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_ce_n | input | 2 | Card-enable pair, active low; 11 means not selected |
| host_reg_n | input | 1 | Space select: high for common memory, low for attribute memory |
| host_oe_n | input | 1 | Host read strobe, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_addr | input | 16 | Host address |
| host_wr_data | input | 16 | Host write data from the pads |
| host_rd_data | output | 16 | Read data toward the pads |
| host_rd_oe | output | 1 | Pad output-enable for read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_wr | output | 1 | Direction of the request: 1 write, 0 read |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Request write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge from the arbiter |

## Verification
A pin change reaches the decoder after two synchronizer edges, so a request shows on the third rising edge after a strobe falls. A dropped strobe removes the pad enable on the second edge. The request falls on the edge after the acknowledge is sampled, and read data is on the pads from that same edge. A cycle-accurate behavioural model in the bench advances on every rising edge from the same pin values, and its outputs are compared with the design's at every falling edge. The directed checks sample at exactly those lags: three falling edges after the strobe for the request, two after the release for the pad enable.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_MEM_RD  = 3'd1,
    ST_MEM_WR  = 3'd2,
    ST_HOLD_RD = 3'd3,
    ST_HOLD_WR = 3'd4
  } pcc_state_e;

  localparam int unsigned CTRL_W = 5;

endpackage

// File: rtl/pcc_rst_sync.sv
module pcc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/pcc_sync.sv
module pcc_sync #(
  parameter int unsigned WIDTH = 5,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      safe_q <= RST_VAL;
    end else begin
      meta_q <= d;
      safe_q <= meta_q;
    end
  end

  assign q = safe_q;

endmodule

// File: rtl/pcc_attr_file.sv
module pcc_attr_file #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned REG_W = 8,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wr_val,
  output logic [REG_W-1:0] rd_val
);

  logic [REG_W-1:0] bank_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (hit) begin
        bank_q[g] <= wr_val;
      end
    end
  end

  assign rd_val = bank_q[idx];

endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ATTR_W = 8,
  parameter int unsigned ATTR_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         ce_n_s,
  input  logic               common_s,
  input  logic               oe_n_s,
  input  logic               we_n_s,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wr_data,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [ATTR_W-1:0]  attr_rd_val,
  output logic               attr_wr_en,
  output logic [ATTR_AW-1:0] attr_idx,
  output logic [ATTR_W-1:0]  attr_wr_val,
  output logic               mem_req,
  output logic               mem_wr,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               host_rd_oe,
  output logic [DATA_W-1:0]  host_rd_data
);

  localparam int unsigned PAD_W = DATA_W - ATTR_W;

  pcc_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              req_ld, rd_ld, rd_from_mem;
  logic              card_on, rd_strobe, wr_strobe, released;

  assign card_on   = (ce_n_s != 2'b11);
  assign rd_strobe = card_on && !oe_n_s;
  assign wr_strobe = card_on && !we_n_s;
  assign released  = oe_n_s && we_n_s;

  // next-state and load enables
  always_comb begin
    state_d     = state_q;
    req_ld      = 1'b0;
    rd_ld       = 1'b0;
    rd_from_mem = 1'b0;
    attr_wr_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_strobe) begin
          if (common_s) begin
            state_d = ST_MEM_RD;
            req_ld  = 1'b1;
          end else begin
            state_d = ST_HOLD_RD;
            rd_ld   = 1'b1;
          end
        end else if (wr_strobe) begin
          if (common_s) begin
            state_d = ST_MEM_WR;
            req_ld  = 1'b1;
          end else begin
            state_d    = ST_HOLD_WR;
            attr_wr_en = 1'b1;
          end
        end
      end
      ST_MEM_RD: begin
        if (mem_ack) begin
          state_d     = ST_HOLD_RD;
          rd_ld       = 1'b1;
          rd_from_mem = 1'b1;
        end
      end
      ST_MEM_WR: begin
        if (mem_ack) state_d = ST_HOLD_WR;
      end
      ST_HOLD_RD, ST_HOLD_WR: begin
        if (released) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rd_d = rd_from_mem ? mem_rdata : {{PAD_W{1'b0}}, attr_rd_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_ld) begin
      addr_q  <= host_addr;
      wdata_q <= host_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_ld) rd_q <= rd_d;
  end

  assign attr_idx     = host_addr[ATTR_AW-1:0];
  assign attr_wr_val  = host_wr_data[ATTR_W-1:0];
  assign mem_req      = (state_q == ST_MEM_RD) || (state_q == ST_MEM_WR);
  assign mem_wr       = (state_q == ST_MEM_WR);
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign host_rd_oe   = (state_q == ST_HOLD_RD) && rd_strobe;
  assign host_rd_data = rd_q;

endmodule

// File: rtl/pcc_target.sv
module pcc_target
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ATTR_REGS = 16,
  parameter int unsigned ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_ce_n,
  input  logic              host_reg_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              host_rd_oe,
  output logic              mem_req,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int unsigned ATTR_AW = $clog2(ATTR_REGS);

  logic              rst_n_i;
  logic [CTRL_W-1:0] ctrl_pins, ctrl_s;
  logic              attr_wr_en;
  logic [ATTR_AW-1:0] attr_idx;
  logic [ATTR_W-1:0]  attr_wr_val, attr_rd_val;

  pcc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign ctrl_pins = {host_ce_n, host_reg_n, host_oe_n, host_we_n};

  pcc_sync #(.WIDTH(CTRL_W), .RST_VAL({CTRL_W{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (ctrl_pins),
    .q     (ctrl_s)
  );

  pcc_attr_file #(.NREGS(ATTR_REGS), .REG_W(ATTR_W)) u_attr (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_en  (attr_wr_en),
    .idx    (attr_idx),
    .wr_val (attr_wr_val),
    .rd_val (attr_rd_val)
  );

  pcc_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ATTR_W (ATTR_W),
    .ATTR_AW(ATTR_AW)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .ce_n_s       (ctrl_s[4:3]),
    .common_s     (ctrl_s[2]),
    .oe_n_s       (ctrl_s[1]),
    .we_n_s       (ctrl_s[0]),
    .host_addr    (host_addr),
    .host_wr_data (host_wr_data),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .attr_rd_val  (attr_rd_val),
    .attr_wr_en   (attr_wr_en),
    .attr_idx     (attr_idx),
    .attr_wr_val  (attr_wr_val),
    .mem_req      (mem_req),
    .mem_wr       (mem_wr),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .host_rd_oe   (host_rd_oe),
    .host_rd_data (host_rd_data)
  );

endmodule

// File: rtl/pcc_target_chk.sv
module pcc_target_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        host_ce_n,
  input logic              host_reg_n,
  input logic              host_oe_n,
  input logic              host_we_n,
  input logic              host_rd_oe,
  input logic              mem_req,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_wr) && $stable(mem_addr) && $stable(mem_wdata)));

  p_drop_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  p_req_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (($past(host_ce_n, 3) != 2'b11) && $past(host_reg_n, 3)
                        && (!$past(host_oe_n, 3) || !$past(host_we_n, 3))));

  p_drive_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_oe |-> (!mem_req && !$past(host_oe_n, 2)));

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_ce_n, 2) == 2'b11) |-> !host_rd_oe);

endmodule

bind pcc_target pcc_target_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pcc_target.sv
`timescale 1ns/1ps
module sim_pcc_target;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  host_ce_n;
  logic        host_reg_n, host_oe_n, host_we_n;
  logic [15:0] host_addr, host_wr_data;
  logic [15:0] host_rd_data;
  logic        host_rd_oe;
  logic        mem_req, mem_wr;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ack;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int lat = 2;
  int req_rises = 0;
  logic prev_req = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcc_target u0 (
    .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .host_reg_n(host_reg_n),
    .host_oe_n(host_oe_n), .host_we_n(host_we_n), .host_addr(host_addr),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data), .host_rd_oe(host_rd_oe),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // memory side: owns the storage, acknowledges after lat idle cycles
  logic [15:0] store [256];
  int ack_cnt = 0;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      mem_rdata = 16'h0;
      ack_cnt = 0;
      for (int i = 0; i < 256; i++) store[i] = {i[7:0], ~i[7:0]};
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (ack_cnt >= lat) begin
        mem_ack = 1'b1;
        ack_cnt = 0;
        if (mem_wr) store[mem_addr[7:0]] = mem_wdata;
        else        mem_rdata = store[mem_addr[7:0]];
      end else begin
        ack_cnt++;
      end
    end
  end

  // behavioural reference, advanced on each rising edge from the pins
  logic [4:0]  q1, q2;
  logic        mr1, mr2;
  int          mst;
  logic [15:0] m_a, m_w, m_rd;
  logic [7:0]  m_attr [16];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 0; mr2 = 0; q1 = 5'h1f; q2 = 5'h1f; mst = 0;
      m_a = 0; m_w = 0; m_rd = 0;
      for (int i = 0; i < 16; i++) m_attr[i] = 8'h00;
    end else begin
      if (mr2) begin
        bit en, rdl, wrl, com;
        en  = (q2[4:3] != 2'b11);
        rdl = en && !q2[1];
        wrl = en && !q2[0];
        com = q2[2];
        case (mst)
          0: if (rdl) begin
               if (com) begin mst = 1; m_a = host_addr; m_w = host_wr_data; end
               else begin m_rd = {8'h00, m_attr[host_addr[3:0]]}; mst = 3; end
             end else if (wrl) begin
               if (com) begin mst = 2; m_a = host_addr; m_w = host_wr_data; end
               else begin m_attr[host_addr[3:0]] = host_wr_data[7:0]; mst = 4; end
             end
          1: if (mem_ack) begin m_rd = mem_rdata; mst = 3; end
          2: if (mem_ack) mst = 4;
          default: if (q2[1] && q2[0]) mst = 0;
        endcase
        q2 = q1;
        q1 = {host_ce_n, host_reg_n, host_oe_n, host_we_n};
      end
      mr2 = mr1;
      mr1 = 1'b1;
    end
  end

  // per-cycle comparison (R5 R10) and request edge counting (R9)
  always @(negedge clk) begin
    bit e_req, e_oe, ok;
    cyc++;
    if (!done) begin
      e_req = (mst == 1) || (mst == 2);
      e_oe  = (mst == 3) && (q2[4:3] != 2'b11) && !q2[1];
      ok = (mem_req === e_req);
      if (e_req) ok = ok && (mem_wr === (mst == 2)) && (mem_addr === m_a) && (mem_wdata === m_w);
      chk(ok, "R5 request port vs model", {15'h0, mem_req, mem_addr}, {15'h0, e_req, m_a});
      ok = (host_rd_oe === e_oe);
      if (e_oe) ok = ok && (host_rd_data === m_rd);
      chk(ok, "R10 read pads vs model", {15'h0, host_rd_oe, host_rd_data}, {15'h0, e_oe, m_rd});
      if (mem_req && !prev_req) req_rises++;
      prev_req = mem_req;
    end
    if (cyc > 40000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<40000 cycles", cyc);
      summary();
      $finish;
    end
  end

  // one host access; common accesses also measure the request lag (R6)
  task automatic access(input logic [1:0] ce, input logic common, input logic rd,
                        input logic [15:0] a, input logic [15:0] d, input int hold,
                        input logic [15:0] exp, input string tag);
    int lag;
    @(negedge clk);
    host_ce_n = ce; host_reg_n = common; host_addr = a; host_wr_data = d;
    @(negedge clk);
    req_rises = 0;
    if (rd) host_oe_n = 1'b0; else host_we_n = 1'b0;
    lag = 0;
    if (common) begin
      while (!mem_req && lag < 10) begin @(negedge clk); lag++; end
      chk(lag == 3, "R6 request lag", lag, 3);
    end
    repeat (hold) @(negedge clk);
    if (rd) begin
      chk(host_rd_oe === 1'b1, {tag, " pad enable"}, {31'h0, host_rd_oe}, 1);
      chk(host_rd_data === exp, {tag, " read data"}, {16'h0, host_rd_data}, {16'h0, exp});
    end
    host_oe_n = 1'b1; host_we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (rd) chk(host_rd_oe === 1'b0, "R10 enable drops two edges after release", {31'h0, host_rd_oe}, 0);
    repeat (3) @(negedge clk);
    host_ce_n = 2'b11;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    host_ce_n = 2'b11; host_reg_n = 1'b1; host_oe_n = 1'b1; host_we_n = 1'b1;
    host_addr = 16'h0; host_wr_data = 16'h0;
    repeat (4) @(negedge clk);
    chk(mem_req === 1'b0, "R11 no request in reset", {31'h0, mem_req}, 0);
    chk(host_rd_oe === 1'b0, "R11 pads idle in reset", {31'h0, host_rd_oe}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem_req === 1'b0, "R11 no request after reset", {31'h0, mem_req}, 0);

    // R11 R8: unwritten attribute register reads zero
    access(2'b00, 1'b0, 1'b1, 16'h0009, 16'h0, 6, 16'h0000, "R11 R8 attribute reset value");

    // R4: common write, then R3 read back
    lat = 3;
    access(2'b00, 1'b1, 1'b0, 16'h0012, 16'hBEEF, 10, 16'h0, "R4");
    chk(store[8'h12] === 16'hBEEF, "R4 memory write data", {16'h0, store[8'h12]}, 16'hBEEF);
    chk(req_rises == 1, "R4 single request", req_rises, 1);
    access(2'b00, 1'b1, 1'b1, 16'h0012, 16'h0, 10, 16'hBEEF, "R3 common read");

    // R5: long acknowledge latency, preset contents
    lat = 12;
    access(2'b01, 1'b1, 1'b1, 16'h0040, 16'h0, 20, 16'h40BF, "R5 slow acknowledge read");
    lat = 1;

    // R7 R2: attribute write makes no memory request
    access(2'b00, 1'b0, 1'b0, 16'h1235, 16'h77A5, 6, 16'h0, "R7");
    chk(req_rises == 0, "R2 attribute write raises no request", req_rises, 0);
    access(2'b00, 1'b0, 1'b1, 16'h0005, 16'h0, 6, 16'h00A5, "R8 attribute read");
    chk(req_rises == 0, "R2 attribute read raises no request", req_rises, 0);
    access(2'b00, 1'b0, 1'b1, 16'hFFF5, 16'h0, 6, 16'h00A5, "R7 high address bits ignored");
    access(2'b00, 1'b0, 1'b0, 16'h000F, 16'h0133, 6, 16'h0, "R7 top register");
    access(2'b00, 1'b0, 1'b1, 16'h000F, 16'h0, 6, 16'h0033, "R8 top register");

    // R1: card not enabled, strobes active
    @(negedge clk);
    host_ce_n = 2'b11; host_reg_n = 1'b1; host_addr = 16'h0012; req_rises = 0;
    host_oe_n = 1'b0;
    begin
      bit seen_oe = 1'b0;
      repeat (10) begin @(negedge clk); if (host_rd_oe) seen_oe = 1'b1; end
      chk(seen_oe == 1'b0, "R1 no drive while disabled", {31'h0, seen_oe}, 0);
    end
    host_oe_n = 1'b1; host_we_n = 1'b0; host_reg_n = 1'b0; host_addr = 16'h0005;
    host_wr_data = 16'h00FF;
    repeat (8) @(negedge clk);
    host_we_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_rises == 0, "R1 no request while disabled", req_rises, 0);
    access(2'b00, 1'b0, 1'b1, 16'h0005, 16'h0, 6, 16'h00A5, "R1 register untouched while disabled");

    // R1: one card-enable line low is enough
    access(2'b10, 1'b1, 1'b1, 16'h0012, 16'h0, 8, 16'hBEEF, "R1 single enable line");

    // R9: long strobes give one request each
    access(2'b00, 1'b1, 1'b1, 16'h0077, 16'h0, 40, 16'h7788, "R9 long read");
    chk(req_rises == 1, "R9 one request per long read", req_rises, 1);
    access(2'b00, 1'b1, 1'b0, 16'h0078, 16'h1357, 40, 16'h0, "R9 long write");
    chk(req_rises == 1, "R9 one request per long write", req_rises, 1);
    chk(store[8'h78] === 16'h1357, "R4 long write data", {16'h0, store[8'h78]}, 16'h1357);

    repeat (5) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule